// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the software-facing side of a simple serial port. A processor reaches it through a word-only register interface. The interface has an address, a size code, separate write and read enables, write data and registered read data. The block turns a write to the transmit data register into a one-cycle character strobe. It queues incoming characters in an eight-entry receive FIFO and hands them out oldest first, one per read of the receive data register. It also keeps the transmit control, receive control and divisor words and presents them on configuration outputs, where the bit-timing logic can use them.

Incoming characters arrive on a valid/ready stream. The block raises `rx_ready` while the queue has room. A character is taken on any cycle in which both `rx_valid` and `rx_ready` are high. If the sender holds `rx_valid` high while `rx_ready` is low, the character is not stored. The block counts it as a drop, and the sender does not need to retry. The transmit side has no back-pressure: every accepted write produces exactly one strobe, and a read of the transmit data register always returns 0, meaning "not full".

A single level interrupt is driven from the receive watermark condition. It stays high while the receive-watermark enable is set and at least one character is waiting. It is recomputed in the same cycle that any enable write, pop or push takes effect. If a cycle has both `bus_we` and `bus_re` high, it is treated as a write only.

Top module: `serial_reg_front`

## Requirements
- R1: After reset, `bus_rdata`, `bus_err`, `tx_valid`, `irq`, `rx_drop_cnt` and all configuration outputs are 0, and `rx_ready` is 1.
- R2: An access is legal only when `bus_size` is 2'b10 (four bytes). Any other size code has no effect on registers or the queue. Such a read returns 0, and the access sets `bus_err`.
- R3: The receive queue holds 8 characters. `rx_ready` is 1 exactly when fewer than 8 are stored. A character offered while `rx_ready` is 0 is discarded and increments `rx_drop_cnt`, which saturates at its maximum.
- R4: A read at offset 0x04 with the queue non-empty removes the oldest character and returns it zero-extended, in arrival order. With the queue empty, the read returns 0x80000000 and removes nothing.
- R5: A write at offset 0x00 drives `tx_valid` high for exactly one cycle, starting on the clock edge that accepts the write, with `tx_data` equal to the low 8 bits of the write data. A read at 0x00 returns 0.
- R6: The words at offsets 0x08 (transmit control), 0x0C (receive control) and 0x18 (divisor) are full 32-bit read/write. They read back the last value written and appear on `cfg_tx_ctrl`, `cfg_rx_ctrl` and `cfg_divisor`.
- R7: Offset 0x10 is the interrupt enable register. Bit 0 is the transmit-watermark enable and bit 1 is the receive-watermark enable; all other bits read 0. Offset 0x14 is the pending register, which uses the same bit positions. Its bit 1 reads 1 while the queue is non-empty and its bit 0 reads 0. Writes to 0x14 are ignored.
- R8: `irq` is 1 exactly when the receive-watermark enable is set and the queue is non-empty. It reflects the new state right after the edge of any enable write, pop or push.
- R9: A pop and a push in the same cycle leave the stored count unchanged and keep first-in first-out order.
- R10: An access with the low two address bits non-zero, at offset 0x1C, or at an offset of 0x20 or above sets `bus_err`, which stays set until reset. Such a read returns 0, and such a write has no effect.
- R11: Read data is registered. It appears after the clock edge that samples `bus_re` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 2 | Access size code, 2'b10 = four bytes |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Sticky illegal-access flag |
| tx_valid | output | 1 | One-cycle transmit character strobe |
| tx_data | output | 8 | Transmit character |
| rx_valid | input | 1 | Incoming character valid |
| rx_data | input | 8 | Incoming character |
| rx_ready | output | 1 | Queue has room |
| rx_drop_cnt | output | DROP_W | Saturating count of discarded characters |
| cfg_tx_ctrl | output | 32 | Transmit control word |
| cfg_rx_ctrl | output | 32 | Receive control word |
| cfg_divisor | output | 32 | Divisor word |
| irq | output | 1 | Receive watermark interrupt |

## Verification
Several behaviours are checked by assertions on every cycle:
- the queue never exceeds its depth, and a full queue that is not popped stays full;
- a same-cycle pop and push keep the count unchanged;
- a refused character bumps the drop counter;
- the transmit strobe follows a transmit write one edge later, carrying its low byte;
- an empty-queue read yields the marker word;
- the error flag never clears;
- the interrupt is never high with the queue empty;
- a badly sized write leaves the divisor unchanged.

Other behaviours only the bench scenarios show: first-in first-out order across a fill, overflow and drain; read-back of the configuration words; the enable and pending bit layout; the interrupt following enable writes; and read data holding between reads.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int REG_COUNT = 7;
  localparam int IDX_TXD = 0;
  localparam int IDX_RXD = 1;
  localparam int IDX_TXC = 2;
  localparam int IDX_RXC = 3;
  localparam int IDX_IEN = 4;
  localparam int IDX_IPD = 5;
  localparam int IDX_DIV = 6;
  localparam int WM_TX_BIT = 0;
  localparam int WM_RX_BIT = 1;
  localparam logic [31:0] RX_EMPTY_WORD = 32'h8000_0000;
  localparam logic [1:0]  SIZE_WORD = 2'b10;
  localparam logic [31:0] WINDOW_BYTES = 32'd32;
endpackage

// File: rtl/srf_bus_decode.sv
module srf_bus_decode
  import srf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  input  logic                 access,
  output logic [REG_COUNT-1:0] sel,
  output logic                 bad
);
  logic       in_window;
  logic       aligned;
  logic       defined;
  logic       good;
  logic [2:0] idx;

  assign idx       = addr[4:2];
  assign aligned   = (addr[1:0] == 2'b00);
  assign in_window = (32'(addr) < WINDOW_BYTES);
  assign defined   = (int'(idx) < REG_COUNT);
  assign good      = access && (size == SIZE_WORD) && aligned && in_window && defined;
  assign bad       = access && !good;

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_sel
    assign sel[i] = good && (idx == 3'(i));
  end
endmodule

// File: rtl/srf_rx_fifo.sv
module srf_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  parameter int DROP_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  output logic                in_ready,
  input  logic                pop,
  output logic [DATA_W-1:0]   head,
  output logic                empty,
  output logic [DROP_W-1:0]   drop_cnt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic              push, do_pop;

  assign in_ready = (count < FULL_CNT);
  assign empty    = (count == '0);
  assign push     = in_valid && in_ready;
  assign do_pop   = pop && !empty;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      drop_cnt <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      if (push && !do_pop)      count <= count + 1'b1;
      else if (!push && do_pop) count <= count - 1'b1;
      if (in_valid && !in_ready && drop_cnt != DROP_MAX) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT && !pop) |=> (count == FULL_CNT));
  a_r3_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && drop_cnt != DROP_MAX) |=> (drop_cnt == $past(drop_cnt) + 1'b1));
  a_r9_pop_push_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (push && do_pop) |=> $stable(count));
endmodule

// File: rtl/srf_irq.sv
module srf_irq
  import srf_pkg::*;
(
  input  logic [1:0] enable,
  input  logic       rx_nonempty,
  output logic [1:0] pending,
  output logic       irq
);
  always_comb begin
    pending = '0;
    pending[WM_RX_BIT] = rx_nonempty;
    pending[WM_TX_BIT] = 1'b0;
  end
  assign irq = |(enable & pending);
endmodule

// File: rtl/serial_reg_front.sv
module serial_reg_front
  import srf_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int DROP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic [DROP_W-1:0] rx_drop_cnt,
  output logic [31:0]       cfg_tx_ctrl,
  output logic [31:0]       cfg_rx_ctrl,
  output logic [31:0]       cfg_divisor,
  output logic              irq
);
  localparam int CHAR_W = 8;

  logic [REG_COUNT-1:0] sel;
  logic                 bad;
  logic                 rd;
  logic                 fifo_empty;
  logic [CHAR_W-1:0]    fifo_head;
  logic [1:0]           ie_q;
  logic [1:0]           pending;
  logic [31:0]          rd_word;

  assign rd = bus_re && !bus_we;

  srf_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (bus_addr),
    .size   (bus_size),
    .access (bus_we || bus_re),
    .sel    (sel),
    .bad    (bad)
  );

  srf_rx_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(CHAR_W), .DROP_W(DROP_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .in_ready (rx_ready),
    .pop      (rd && sel[IDX_RXD]),
    .head     (fifo_head),
    .empty    (fifo_empty),
    .drop_cnt (rx_drop_cnt)
  );

  srf_irq u_irq (
    .enable      (ie_q),
    .rx_nonempty (!fifo_empty),
    .pending     (pending),
    .irq         (irq)
  );

  always_comb begin
    rd_word = '0;
    if (sel[IDX_RXD])      rd_word = fifo_empty ? RX_EMPTY_WORD : {{(32-CHAR_W){1'b0}}, fifo_head};
    else if (sel[IDX_TXC]) rd_word = cfg_tx_ctrl;
    else if (sel[IDX_RXC]) rd_word = cfg_rx_ctrl;
    else if (sel[IDX_IEN]) rd_word = {30'b0, ie_q};
    else if (sel[IDX_IPD]) rd_word = {30'b0, pending};
    else if (sel[IDX_DIV]) rd_word = cfg_divisor;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata   <= '0;
      bus_err     <= 1'b0;
      tx_valid    <= 1'b0;
      tx_data     <= '0;
      ie_q        <= '0;
      cfg_tx_ctrl <= '0;
      cfg_rx_ctrl <= '0;
      cfg_divisor <= '0;
    end else begin
      tx_valid <= bus_we && sel[IDX_TXD];
      if (bus_we && sel[IDX_TXD]) tx_data <= bus_wdata[CHAR_W-1:0];
      if (bus_we && sel[IDX_TXC]) cfg_tx_ctrl <= bus_wdata;
      if (bus_we && sel[IDX_RXC]) cfg_rx_ctrl <= bus_wdata;
      if (bus_we && sel[IDX_IEN]) ie_q <= bus_wdata[1:0];
      if (bus_we && sel[IDX_DIV]) cfg_divisor <= bus_wdata;
      if (rd) bus_rdata <= rd_word;
      if (bad) bus_err <= 1'b1;
    end
  end

  a_r5_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel[IDX_TXD]) |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));
  a_r5_no_spurious_tx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_we && sel[IDX_TXD]));
  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel[IDX_RXD] && fifo_empty) |=> (bus_rdata == RX_EMPTY_WORD));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err);
  a_r8_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !fifo_empty);
  a_r2_bad_size_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_size != SIZE_WORD) |=> $stable(cfg_divisor));
endmodule

// File: tb/serial_reg_front_bench.sv
module serial_reg_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'b10;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic [7:0]  rx_drop_cnt;
  logic [31:0] cfg_tx_ctrl, cfg_rx_ctrl, cfg_divisor;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rd_q[$];
  string       rd_tag_q[$];
  logic [7:0]  tx_q[$];

  always #2 clk = ~clk;

  serial_reg_front u_serial_reg_front (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_drop_cnt(rx_drop_cnt),
    .cfg_tx_ctrl(cfg_tx_ctrl), .cfg_rx_ctrl(cfg_rx_ctrl), .cfg_divisor(cfg_divisor),
    .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d, logic [1:0] sz = 2'b10);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
    if (a == 8'h00 && sz == 2'b10) tx_q.push_back(d[7:0]);
    @(negedge clk);
    bus_we = 1'b0; bus_size = 2'b10;
  endtask

  task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag, logic [1:0] sz = 2'b10);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_re = 1'b1;
    rd_q.push_back(exp); rd_tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0; bus_size = 2'b10;
  endtask

  task automatic rx_send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic read_and_send(logic [31:0] exp, logic [7:0] b);
    @(negedge clk);
    bus_addr = 8'h04; bus_re = 1'b1; rx_valid = 1'b1; rx_data = b;
    rd_q.push_back(exp); rd_tag_q.push_back("R9 pop with push");
    @(negedge clk);
    bus_re = 1'b0; rx_valid = 1'b0;
  endtask

  // Read monitor: compares registered read data after each sampled read.
  initial begin
    forever begin
      @(posedge clk);
      if (bus_re && !bus_we) begin
        @(negedge clk);
        if (rd_q.size() == 0) chk("R11 unexpected read", bus_rdata, 32'hx);
        else chk(rd_tag_q.pop_front(), bus_rdata, rd_q.pop_front());
      end
    end
  end

  // Transmit monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (tx_valid) begin
        if (tx_q.size() == 0) chk("R5 unexpected tx strobe", {24'b0, tx_data}, 32'hx);
        else chk("R5 tx character", {24'b0, tx_data}, {24'b0, tx_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 err", {31'b0, bus_err}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    chk("R1 drop", {24'b0, rx_drop_cnt}, 0);
    chk("R1 divisor", cfg_divisor, 0);

    bus_read(8'h04, 32'h8000_0000, "R4 empty read");
    bus_write(8'h00, 32'h0000_01A5);
    bus_read(8'h00, 0, "R5 tx read zero");

    bus_write(8'h08, 32'hDEAD_BEEF);
    bus_write(8'h0C, 32'h0BAD_F00D);
    bus_write(8'h18, 32'h0000_1234);
    bus_read(8'h08, 32'hDEAD_BEEF, "R6 tx ctrl");
    bus_read(8'h0C, 32'h0BAD_F00D, "R6 rx ctrl");
    bus_read(8'h18, 32'h0000_1234, "R6 divisor");
    chk("R6 cfg_tx_ctrl", cfg_tx_ctrl, 32'hDEAD_BEEF);
    chk("R6 cfg_divisor", cfg_divisor, 32'h0000_1234);

    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_read(8'h10, 32'h3, "R7 enable bits");
    bus_read(8'h14, 32'h0, "R7 pending empty");
    chk("R8 irq empty queue", {31'b0, irq}, 0);

    rx_send(8'h11);
    chk("R8 irq after push", {31'b0, irq}, 1);
    bus_read(8'h14, 32'h2, "R7 pending non-empty");
    bus_write(8'h14, 32'h0);
    bus_read(8'h14, 32'h2, "R7 pending write ignored");
    bus_write(8'h10, 32'h1);
    chk("R8 irq rx enable clear", {31'b0, irq}, 0);
    bus_write(8'h10, 32'h2);
    chk("R8 irq rx enable set", {31'b0, irq}, 1);

    for (int i = 2; i <= 8; i++) rx_send(8'h10 + 8'(i));
    chk("R3 ready low when full", {31'b0, rx_ready}, 0);
    rx_send(8'h99);
    chk("R3 drop counted", {24'b0, rx_drop_cnt}, 1);

    bus_read(8'h04, 32'h11, "R4 pop oldest");
    chk("R3 ready after pop", {31'b0, rx_ready}, 1);
    read_and_send(32'h12, 8'h20);
    chk("R9 count kept", {31'b0, rx_ready}, 1);
    for (int i = 3; i <= 8; i++) bus_read(8'h04, 32'h10 + 32'(i), "R4 drain order");
    bus_read(8'h04, 32'h20, "R9 pushed byte order");
    chk("R8 irq after drain", {31'b0, irq}, 0);
    bus_read(8'h04, 32'h8000_0000, "R4 empty after drain");

    bus_read(8'h1C, 0, "R10 undefined read");
    chk("R10 err set", {31'b0, bus_err}, 1);
    bus_write(8'h19, 32'h5555_5555);
    bus_read(8'h40, 0, "R10 out of window read");
    bus_read(8'h18, 32'h0000_1234, "R10 misaligned write ignored");
    repeat (3) @(negedge clk);
    chk("R11 rdata held", bus_rdata, 32'h0000_1234);
    chk("R10 err sticky", {31'b0, bus_err}, 1);

    do_reset();
    chk("R1 err cleared", {31'b0, bus_err}, 0);
    rx_send(8'h33);
    bus_read(8'h04, 0, "R2 byte-size read", 2'b00);
    chk("R2 err on size", {31'b0, bus_err}, 1);
    bus_write(8'h18, 32'hABCD_0000, 2'b11);
    bus_read(8'h18, 0, "R2 wide write ignored");
    bus_read(8'h04, 32'h33, "R2 queue not popped");

    repeat (4) @(negedge clk);
    chk("R5 tx queue drained", 32'(tx_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule